// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is a W-bit port that lets one peripheral both send and receive over a single shared bus. It has two latches. The CPU loads the transmit latch with a write strobe. The peripheral loads the receive latch with its own strobe. The port places transmit data on the shared bus only while the peripheral holds its acknowledge line low. At every other time the bus is released, which is modelled as a data-out vector plus an output-enable.

Two status flags report the state of the latches. The transmit-full flag is active low, and the receive-full flag is active high. A single interrupt line merges a receive condition and a transmit condition. Each condition has its own enable flip-flop, and software sets or clears these enables through a single-bit set/reset command. A mode-change pulse from the surrounding control logic returns every flag and enable to its idle value.

All handshake lines are plain level strobes, sampled on the clock. None of them is a valid/ready pair, and the block never applies back-pressure. The peripheral and the CPU may interleave events in any order, provided each write comes before its acknowledge and each strobe comes before its read. If a new strobe arrives before the CPU has read the previous byte, that byte is overwritten.

Top module: `bsport_top`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, and both interrupt enables are 0.
- R2: per_oe is 1 exactly while per_ack_n is 0. While per_oe is 1, per_dout equals the transmit latch. While per_oe is 0, per_dout is all zeros.
- R3: A rising edge of cpu_wr_n (low in the previous sampled cycle, high now) loads cpu_wdata into the transmit latch, and obf_n reads 0 from the next cycle on.
- R4: A cycle with per_ack_n low and no write rising edge sets obf_n to 1 on the next cycle. When both occur in the same cycle, the write wins.
- R5: Each cycle with per_stb_n low loads per_din into the receive latch and sets ibf on the next cycle. This holds even if ibf is already 1, in which case the latch is overwritten and the flag stays set.
- R6: A rising edge of cpu_rd_n clears ibf on the next cycle, unless per_stb_n is low in that same cycle.
- R7: intr = (ibf & rx_enable & per_stb_n & cpu_rd_n) | (obf_n & tx_enable & per_ack_n & cpu_wr_n), evaluated combinationally from the current flags and pins.
- R8: When bsr_we is 1, the enable selected by bsr_sel (0 = transmit enable, 1 = receive enable) takes the value of bsr_val on the next cycle. The other enable is unchanged.
- R9: A cycle with mode_chg high sets obf_n to 1 and clears ibf and both enables, taking priority over every other event.
- R10: cpu_rdata always presents the receive latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_chg | input | 1 | Mode-change pulse that clears flags and enables |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wdata | input | W | CPU write data |
| cpu_rdata | output | W | Receive latch contents |
| bsr_we | input | 1 | Enable set/reset command |
| bsr_sel | input | 1 | Enable select: 0 = transmit, 1 = receive |
| bsr_val | input | 1 | Value written to the selected enable |
| per_stb_n | input | 1 | Peripheral receive strobe, active low |
| per_ack_n | input | 1 | Peripheral acknowledge, active low |
| per_din | input | W | Shared bus, inbound value |
| per_dout | output | W | Shared bus, outbound value |
| per_oe | output | 1 | Shared bus drive enable |
| obf_n | output | 1 | Transmit latch full, active low |
| ibf | output | 1 | Receive latch full |
| intr | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with W = 8, so random data reaches every byte value on both latches. The 8-bit width also makes an overwrite visible as a changed receive value. The stimulus randomizes every strobe independently on each cycle. This reaches the same-cycle collisions of R4, R5, R6 and R9 (write with acknowledge, strobe with read, and mode change with anything else), which directed sequences alone would seldom produce.

// File: rtl/bsport_pkg.sv
package bsport_pkg;
  typedef enum logic {
    SEL_TX = 1'b0,
    SEL_RX = 1'b1
  } inte_sel_e;
endpackage

// File: rtl/bsport_tx.sv
module bsport_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_n,
  input  logic [W-1:0] wdata,
  input  logic         ack_n,
  output logic [W-1:0] out_q,
  output logic         obf_n
);
  logic wr_q;
  logic wr_rise;

  assign wr_rise = wr_n & ~wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      out_q <= '0;
      obf_n <= 1'b1;
    end else begin
      wr_q <= wr_n;
      if (clr) begin
        obf_n <= 1'b1;
      end else if (wr_rise) begin
        out_q <= wdata;
        obf_n <= 1'b0;
      end else if (!ack_n) begin
        obf_n <= 1'b1;
      end
    end
  end

  // R3
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !clr) |=> (!obf_n && out_q == $past(wdata)));
  // R4
  a_r4_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !wr_rise) |=> obf_n);
  // R2: the latch moves only on a write edge
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rise || clr) |=> $stable(out_q));
endmodule

// File: rtl/bsport_rx.sv
module bsport_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         rd_n,
  input  logic         stb_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] in_q,
  output logic         ibf
);
  logic rd_q;
  logic rd_rise;

  assign rd_rise = rd_n & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      in_q <= '0;
      ibf  <= 1'b0;
    end else begin
      rd_q <= rd_n;
      if (clr) begin
        ibf <= 1'b0;
      end else if (!stb_n) begin
        in_q <= din;
        ibf  <= 1'b1;
      end else if (rd_rise) begin
        ibf <= 1'b0;
      end
    end
  end

  // R5
  a_r5_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !clr) |=> (ibf && in_q == $past(din)));
  // R6
  a_r6_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && stb_n) |=> !ibf);
endmodule

// File: rtl/bsport_irq.sv
module bsport_irq
  import bsport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bsr_we,
  input  logic bsr_sel,
  input  logic bsr_val,
  input  logic ibf,
  input  logic obf_n,
  input  logic stb_n,
  input  logic rd_n,
  input  logic ack_n,
  input  logic wr_n,
  output logic intr
);
  logic en_tx;
  logic en_rx;
  logic rx_term;
  logic tx_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_tx <= 1'b0;
      en_rx <= 1'b0;
    end else if (clr) begin
      en_tx <= 1'b0;
      en_rx <= 1'b0;
    end else if (bsr_we) begin
      if (inte_sel_e'(bsr_sel) == SEL_RX) en_rx <= bsr_val;
      else                                en_tx <= bsr_val;
    end
  end

  assign rx_term = ibf & en_rx & stb_n & rd_n;
  assign tx_term = obf_n & en_tx & ack_n & wr_n;
  assign intr    = rx_term | tx_term;

  // R8
  a_r8_rx_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_we && bsr_sel && !clr) |=> (en_rx == $past(bsr_val) && $stable(en_tx)));
  // R7: no request while both enables are clear
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx && !en_tx) |-> !intr);
endmodule

// File: rtl/bsport_top.sv
module bsport_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_chg,
  input  logic         cpu_wr_n,
  input  logic         cpu_rd_n,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         bsr_we,
  input  logic         bsr_sel,
  input  logic         bsr_val,
  input  logic         per_stb_n,
  input  logic         per_ack_n,
  input  logic [W-1:0] per_din,
  output logic [W-1:0] per_dout,
  output logic         per_oe,
  output logic         obf_n,
  output logic         ibf,
  output logic         intr
);
  logic [W-1:0] tx_latch;

  bsport_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .wr_n(cpu_wr_n),
    .wdata(cpu_wdata), .ack_n(per_ack_n), .out_q(tx_latch), .obf_n(obf_n)
  );

  bsport_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .rd_n(cpu_rd_n),
    .stb_n(per_stb_n), .din(per_din), .in_q(cpu_rdata), .ibf(ibf)
  );

  bsport_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .bsr_we(bsr_we),
    .bsr_sel(bsr_sel), .bsr_val(bsr_val), .ibf(ibf), .obf_n(obf_n),
    .stb_n(per_stb_n), .rd_n(cpu_rd_n), .ack_n(per_ack_n), .wr_n(cpu_wr_n),
    .intr(intr)
  );

  assign per_oe   = ~per_ack_n;
  assign per_dout = per_oe ? tx_latch : '0;

  // R9
  a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (obf_n && !ibf));
  // R2
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    !per_oe |-> (per_dout == '0));
endmodule

// File: tb/bsport_top_bench.sv
module bsport_top_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_chg = 1'b0, cpu_wr_n = 1'b1, cpu_rd_n = 1'b1;
  logic [W-1:0] cpu_wdata = '0, per_din = '0;
  logic bsr_we = 1'b0, bsr_sel = 1'b0, bsr_val = 1'b0;
  logic per_stb_n = 1'b1, per_ack_n = 1'b1;
  logic [W-1:0] cpu_rdata, per_dout;
  logic per_oe, obf_n, ibf, intr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_obf_n = 1, m_ibf = 0, m_entx = 0, m_enrx = 0, m_pwr = 1, m_prd = 1;
  int m_out = 0, m_in = 0;

  always #5 clk = ~clk;

  bsport_top #(.W(W)) u_bsport_top (
    .clk(clk), .rst_n(rst_n), .mode_chg(mode_chg), .cpu_wr_n(cpu_wr_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .per_stb_n(per_stb_n), .per_ack_n(per_ack_n), .per_din(per_din),
    .per_dout(per_dout), .per_oe(per_oe), .obf_n(obf_n), .ibf(ibf), .intr(intr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_intr();
    return ((m_ibf && m_enrx && per_stb_n && cpu_rd_n) ||
            (m_obf_n && m_entx && per_ack_n && cpu_wr_n)) ? 1 : 0;
  endfunction

  // reference model advanced on every edge, then compared
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        bit wr_rise, rd_rise;
        wr_rise = cpu_wr_n && !m_pwr;
        rd_rise = cpu_rd_n && !m_prd;
        if (mode_chg) begin
          m_obf_n = 1; m_ibf = 0; m_entx = 0; m_enrx = 0;
        end else begin
          if (wr_rise) begin m_out = cpu_wdata; m_obf_n = 0; end
          else if (!per_ack_n) m_obf_n = 1;
          if (!per_stb_n) begin m_in = per_din; m_ibf = 1; end
          else if (rd_rise) m_ibf = 0;
          if (bsr_we) begin
            if (bsr_sel) m_enrx = bsr_val; else m_entx = bsr_val;
          end
        end
        m_pwr = cpu_wr_n;
        m_prd = cpu_rd_n;
      end
      #1;
      chk("R3/R4 obf_n", obf_n, m_obf_n);
      chk("R5/R6 ibf", ibf, m_ibf);
      chk("R10 cpu_rdata", cpu_rdata, m_in);
      chk("R2 per_oe", per_oe, !per_ack_n);
      chk("R2 per_dout", per_dout, per_ack_n ? 0 : m_out);
      chk("R7 intr", intr, m_intr());
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    mode_chg = 0; cpu_wr_n = 1; cpu_rd_n = 1; bsr_we = 0;
    per_stb_n = 1; per_ack_n = 1;
  endtask

  initial begin
    step(3);
    chk("R1 obf_n", obf_n, 1);
    chk("R1 ibf", ibf, 0);
    chk("R1 intr", intr, 0);
    rst_n = 1;
    step(2);
    // R8: enable the transmit term; obf_n idle high gives a request
    bsr_we = 1; bsr_sel = 0; bsr_val = 1; step(); idle(); step();
    chk("R8 tx enable", intr, 1);
    // R3: write 0xA5
    cpu_wdata = 8'hA5; cpu_wr_n = 0; step(); chk("R7 wr low masks", intr, 0);
    cpu_wr_n = 1; step(); step();
    chk("R3 obf_n after write", obf_n, 0);
    chk("R2 released", per_oe, 0);
    // R2/R4: acknowledge
    per_ack_n = 0; #1; chk("R2 drive", per_dout, 8'hA5);
    step(); chk("R4 ack clears", obf_n, 1);
    per_ack_n = 1; step(); chk("R7 tx term", intr, 1);
    // R4: write edge and ack in the same cycle, write wins
    cpu_wdata = 8'h3C; cpu_wr_n = 0; step();
    cpu_wr_n = 1; per_ack_n = 0; step(); per_ack_n = 1; step();
    chk("R4 write wins", obf_n, 0);
    // R5/R6: strobe, overwrite, read
    bsr_we = 1; bsr_sel = 1; bsr_val = 1; step(); idle();
    per_din = 8'h11; per_stb_n = 0; step(); per_stb_n = 1; step();
    chk("R5 ibf", ibf, 1); chk("R10 rdata", cpu_rdata, 8'h11);
    per_din = 8'h22; per_stb_n = 0; step(); per_stb_n = 1; step();
    chk("R5 overwrite", cpu_rdata, 8'h22); chk("R5 still full", ibf, 1);
    cpu_rd_n = 0; step(); cpu_rd_n = 1; step(); step();
    chk("R6 read clears", ibf, 0);
    // R9
    per_stb_n = 0; step(); per_stb_n = 1; mode_chg = 1; step(); idle(); step();
    chk("R9 ibf", ibf, 0); chk("R9 obf_n", obf_n, 1); chk("R9 intr", intr, 0);
    // random interleavings
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      cpu_wr_n  = r[0] | r[1];
      cpu_rd_n  = r[2] | r[3];
      per_stb_n = r[4] | r[5];
      per_ack_n = r[6] | r[7];
      bsr_we    = r[8] & r[9];
      bsr_sel   = r[10];
      bsr_val   = r[11] | r[12];
      mode_chg  = (r[20:15] == 0);
      cpu_wdata = r[31:24];
      per_din   = r[23:16];
      step();
    end
    idle(); step(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule